// File: doc/BRIEF.md
# Lamp Dimming PWM to Display Dimming Converter

This block watches a slow lamp-dimming PWM signal and turns its duty cycle into a dimming level for a two-grid multiplexed fluorescent display. It counts ticks over each full input period (rising edge to rising edge) and counts how many of those ticks were high. From those two counts it works out the duty as one of 80 levels in 1.25% steps, rounding to the nearest level. That level becomes one of 65 display steps, or a full-brightness code. The step sets how long each grid and the segment lines are on in every display slot.

A display frame has two equal slots, one for each grid. In each slot the segment window opens at the start of the slot. The grid window opens a fixed lead time later. Both windows close together. Their length is the on-time taken from the current step, or the longest allowed window while the bright-mode input is high. The on-time and the bright flag are sampled once, at each slot boundary, so no window is ever cut short or stretched by a change in the middle of a slot.

If the input stops toggling, the last step is kept. A rising edge that arrives after a timeout only starts a new measurement. It does not produce a result of its own.

Top module: `lamp_pwm_conv`

## Requirements
- R1: With H high ticks in a P-tick period, level L = round(80*H/P), where an exact half rounds up. For 16 <= L <= 79, step_out = 79 - L once the period that follows has ended and the level search has finished (at most 81 clocks later).
- R2: A level below 16 (duty under 20%) gives step_out = 64.
- R3: Level 80 gives step_out = 127, the full-brightness code.
- R4: The on-time in bit times is MAX_ON - (MAX_ON/64)*step for steps 0..63 (256 down to 4 by default), MAX_ON/128 for step 64, and SLOT - LEAD - GAP for code 127, where SLOT is half the frame.
- R5: One bit time is BT_DIV clocks. grid_out[0] is on only in the first slot of the frame and grid_out[1] only in the second. Each grid is on for exactly the on-time, starting LEAD bit times after its slot begins.
- R6: seg_out equals seg_data from the start of each slot for LEAD + on-time bit times, and is zero for the rest of the slot.
- R7: While bright is high, every slot uses the full on-time SLOT - LEAD - GAP, whatever the measured step. step_out is not changed by bright.
- R8: If no rising edge arrives within TIMEOUT ticks of the previous one, the measurement is dropped and step_out is held. The next rising edge only starts a new measurement, so step_out does not change at that edge.
- R9: The on-time and bright are sampled at each slot boundary. Every grid pulse therefore has the length of either the old or the new setting, never a mix of the two.
- R10: After reset, step_out is 64 and both grid outputs are low.
- R11: While the input duty stays the same, step_out stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Lamp PWM input, already synchronized to clk |
| bright | input | 1 | High forces the full on-time in every slot |
| seg_data | input | NSEG | Latched segment pattern |
| seg_out | output | NSEG | Gated segment drive |
| grid_out | output | 2 | Grid drive, bit 0 = first slot, bit 1 = second slot |
| step_out | output | 7 | Current step, 0..64, or 127 for full |

## Verification
Two things can happen in the same clock: the level search finishing a new step, and a slot boundary sampling the on-time. The bench changes the input duty many times while the display keeps running, so these updates land at arbitrary points within the slots, some of them on a boundary. Every finished grid pulse is then measured, and each one must have the width of either the setting before the change or the setting after it. The bright input is also toggled while the display is running, and is judged the same way.

// File: rtl/lamp_pwm_conv.sv
module lamp_pwm_conv #(
  parameter int NSEG     = 30,
  parameter int TICK_DIV = 1,
  parameter int CNT_W    = 12,
  parameter int TIMEOUT  = 4000,
  parameter int BT_DIV   = 4,
  parameter int FRAME_BT = 2048,
  parameter int MAX_ON   = 256,
  parameter int LEAD_BT  = 3,
  parameter int GAP_BT   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic            bright,
  input  logic [NSEG-1:0] seg_data,
  output logic [NSEG-1:0] seg_out,
  output logic [1:0]      grid_out,
  output logic [6:0]      step_out
);
  localparam int SLOT_BT   = FRAME_BT / 2;
  localparam int SLOT_W    = $clog2(SLOT_BT);
  localparam int ON_W      = $clog2(SLOT_BT + 1);
  localparam int PW        = ON_W + 1;
  localparam int STEP_BT   = MAX_ON / 64;
  localparam int FLOOR_ON  = MAX_ON / 128;
  localparam int FULL_ON   = SLOT_BT - LEAD_BT - GAP_BT;
  localparam int MW        = CNT_W + 9;
  localparam int DV_W      = $clog2(BT_DIV + 1);
  localparam int LEVELS    = 80;
  localparam int MIN_LVL   = 16;
  localparam logic [6:0] FULL_CODE = 7'd127;
  localparam logic [6:0] DIM_CODE  = 7'd64;

  logic tick;
  generate
    if (TICK_DIV > 1) begin : g_tick
      localparam int TK_W = $clog2(TICK_DIV);
      logic [TK_W-1:0] tk_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || tk_cnt == TK_W'(TICK_DIV - 1)) tk_cnt <= '0;
        else tk_cnt <= tk_cnt + 1'b1;
      end
      assign tick = (tk_cnt == TK_W'(TICK_DIV - 1));
    end else begin : g_notick
      assign tick = 1'b1;
    end
  endgenerate

  logic pwm_q, armed;
  logic [CNT_W-1:0] per_cnt, hi_cnt;
  wire rise = pwm_in & ~pwm_q;
  wire meas_done = rise & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      armed   <= 1'b0;
      per_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      pwm_q <= pwm_in;
      if (rise) begin
        armed   <= 1'b1;
        per_cnt <= CNT_W'(tick);
        hi_cnt  <= CNT_W'(tick);
      end else if (armed && tick) begin
        if (per_cnt == CNT_W'(TIMEOUT)) armed <= 1'b0;
        else begin
          per_cnt <= per_cnt + 1'b1;
          hi_cnt  <= hi_cnt + CNT_W'(pwm_in);
        end
      end
    end
  end

  logic          busy;
  logic [MW-1:0] tgt, acc, two_p;
  logic [6:0]    lvl, step_q;
  wire step_up = busy && (lvl < 7'(LEVELS)) && (tgt >= acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tgt    <= '0;
      acc    <= '0;
      two_p  <= '0;
      lvl    <= '0;
      step_q <= DIM_CODE;
    end else if (meas_done) begin
      busy  <= 1'b1;
      tgt   <= MW'(hi_cnt) * MW'(2 * LEVELS);
      acc   <= MW'(per_cnt);
      two_p <= MW'(per_cnt) << 1;
      lvl   <= '0;
    end else if (step_up) begin
      lvl <= lvl + 1'b1;
      acc <= acc + two_p;
    end else if (busy) begin
      busy <= 1'b0;
      if (lvl == 7'(LEVELS))      step_q <= FULL_CODE;
      else if (lvl < 7'(MIN_LVL)) step_q <= DIM_CODE;
      else                        step_q <= 7'(LEVELS - 1) - lvl;
    end
  end

  assign step_out = step_q;

  logic [ON_W-1:0] on_map, on_lat;
  always_comb begin
    if (step_q == FULL_CODE)     on_map = ON_W'(FULL_ON);
    else if (step_q == DIM_CODE) on_map = ON_W'(FLOOR_ON);
    else on_map = ON_W'(MAX_ON) - ON_W'(STEP_BT) * ON_W'(step_q);
  end

  logic [DV_W-1:0]   dv;
  logic [SLOT_W-1:0] pos;
  logic              slot;
  wire bt_end   = (dv == DV_W'(BT_DIV - 1));
  wire slot_end = bt_end && (pos == SLOT_W'(SLOT_BT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv     <= '0;
      pos    <= '0;
      slot   <= 1'b0;
      on_lat <= ON_W'(FLOOR_ON);
    end else begin
      dv <= bt_end ? '0 : dv + 1'b1;
      if (bt_end) pos <= slot_end ? '0 : pos + 1'b1;
      if (slot_end) begin
        slot   <= ~slot;
        on_lat <= bright ? ON_W'(FULL_ON) : on_map;
      end
    end
  end

  wire [PW-1:0] seg_end = PW'(LEAD_BT) + PW'(on_lat);
  wire seg_win = PW'(pos) < seg_end;
  wire grd_win = seg_win && (PW'(pos) >= PW'(LEAD_BT));

  assign seg_out  = seg_win ? seg_data : '0;
  assign grid_out = {slot & grd_win, ~slot & grd_win};
endmodule

// File: rtl/lamp_pwm_conv_chk.sv
module lamp_pwm_conv_chk #(
  parameter int NSEG = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSEG-1:0] seg_data,
  input logic [NSEG-1:0] seg_out,
  input logic [1:0]      grid_out,
  input logic [6:0]      step_out
);
  AST_GRID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grid_out) <= 1); // R5

  AST_GRID_UNDER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_out != 2'b00) |-> (seg_out == seg_data)); // R6

  AST_SEG_NO_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_out & ~seg_data) == '0); // R6

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_out <= 7'd64) || (step_out == 7'd127)); // R1

  AST_GRID_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grid_out[0]) |-> $past(grid_out[0], 2)); // R4
endmodule

bind lamp_pwm_conv lamp_pwm_conv_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_data(seg_data), .seg_out(seg_out),
  .grid_out(grid_out), .step_out(step_out)
);

// File: tb/sim_lamp_pwm_conv.sv
module sim_lamp_pwm_conv;
  localparam int NSEG  = 30;
  localparam int FRAME = 1024;
  localparam int BTD   = 4;
  localparam int LEAD  = 3;
  localparam int FULL  = FRAME / 2 - LEAD - 8;
  localparam int FRAME_CLK = FRAME * BTD;
  localparam int NV = 8;
  localparam int V_HI[NV]   = '{158, 100, 121,  32, 30, 159, 150,  80};
  localparam int V_PER[NV]  = '{160, 160, 160, 160, 160, 160, 200, 160};
  localparam int V_STEP[NV] = '{  0,  29,  18,  63, 64, 127,  19,  39};
  localparam int V_ON[NV]   = '{256, 140, 184,   4,  2, FULL, 180, 100};

  logic clk = 1'b0, rst_n = 1'b0, pwm_in = 1'b0, bright = 1'b0;
  logic [NSEG-1:0] seg_data = 30'h15555555;
  logic [NSEG-1:0] seg_out;
  logic [1:0] grid_out;
  logic [6:0] step_out;

  always #4 clk = ~clk;

  lamp_pwm_conv #(.NSEG(NSEG), .TIMEOUT(1000), .BT_DIV(BTD), .FRAME_BT(FRAME)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .bright(bright),
    .seg_data(seg_data), .seg_out(seg_out), .grid_out(grid_out), .step_out(step_out)
  );

  int nchk = 0, nfail = 0;
  bit run = 1'b0;
  int hi_len = 80, per_len = 160, cur_h, cur_p;
  int g0c = 0, g1c = 0, s0c = 0, w0 = 0, w1 = 0, ws = 0;
  int exp_a = 2, exp_b = 2, mix_bad = 0, leak = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  initial forever begin
    if (!run) begin
      pwm_in = 1'b0;
      @(negedge clk);
    end else begin
      cur_h = hi_len;
      cur_p = per_len;
      pwm_in = 1'b1;
      repeat (cur_h) @(negedge clk);
      pwm_in = 1'b0;
      repeat (cur_p - cur_h) @(negedge clk);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if ((seg_out & ~seg_data) != '0 || grid_out == 2'b11) leak++;
      if (grid_out[0]) g0c++;
      else if (g0c != 0) begin
        w0 = g0c;
        if (w0 != exp_a * BTD && w0 != exp_b * BTD) mix_bad++;
        g0c = 0;
      end
      if (grid_out[1]) g1c++;
      else if (g1c != 0) begin w1 = g1c; g1c = 0; end
      if (seg_out[0]) s0c++;
      else if (s0c != 0) begin ws = s0c; s0c = 0; end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_out == 7'd64, "R10", step_out, 64);
    chk(grid_out == 2'b00, "R10", grid_out, 0);

    for (int i = 0; i < NV; i++) begin
      hi_len = V_HI[i];
      per_len = V_PER[i];
      exp_b = V_ON[i];
      run = 1'b1;
      repeat (5 * V_PER[i] + 100) @(negedge clk);
      chk(step_out == 7'(V_STEP[i]),
          (V_STEP[i] == 127) ? "R3" : (V_STEP[i] == 64) ? "R2" : "R1",
          step_out, V_STEP[i]);
      repeat (2 * FRAME_CLK + 100) @(negedge clk);
      chk(w0 == V_ON[i] * BTD, "R4", w0, V_ON[i] * BTD);
      chk(w1 == V_ON[i] * BTD, "R5", w1, V_ON[i] * BTD);
      chk(ws == (LEAD + V_ON[i]) * BTD, "R6", ws, (LEAD + V_ON[i]) * BTD);
      chk(step_out == 7'(V_STEP[i]), "R11", step_out, V_STEP[i]);
      exp_a = exp_b;
    end

    exp_b = FULL;
    bright = 1'b1;
    repeat (2 * FRAME_CLK + 100) @(negedge clk);
    chk(w0 == FULL * BTD, "R7", w0, FULL * BTD);
    chk(step_out == 7'd39, "R7", step_out, 39);
    exp_a = FULL;
    exp_b = 100;
    bright = 1'b0;
    repeat (2 * FRAME_CLK + 100) @(negedge clk);
    chk(w0 == 100 * BTD, "R7", w0, 100 * BTD);
    exp_a = 100;

    run = 1'b0;
    repeat (1400) @(negedge clk);
    chk(step_out == 7'd39, "R8", step_out, 39);
    hi_len = 20;
    per_len = 160;
    exp_b = 2;
    run = 1'b1;
    repeat (120) @(negedge clk);
    chk(step_out == 7'd39, "R8", step_out, 39);
    repeat (5 * 160) @(negedge clk);
    chk(step_out == 7'd64, "R2", step_out, 64);
    repeat (2 * FRAME_CLK + 100) @(negedge clk);
    chk(w0 == 2 * BTD, "R4", w0, 2 * BTD);

    chk(mix_bad == 0, "R9", mix_bad, 0);
    chk(leak == 0, "R6", leak, 0);
    finish_run();
  end
endmodule